// File: doc/BRIEF.md
# Audio InfoFrame Packet Builder

The block turns a set of audio description fields into a complete audio InfoFrame packet and streams it out one byte per handshake. A pulse on the start input snapshots the coding type, channel count, sample frequency code, sample size code, speaker allocation, downmix-inhibit flag and level-shift value. From that snapshot the block derives the three fixed header bytes and ten payload bytes, forms the checksum and then presents the bytes on a valid/ready stream with a last marker.

The checksum comes first in the wire order, after the header and ahead of the payload. The block therefore totals the packet before it sends the first byte. A parameter picks how the total is formed: a one-byte-per-cycle sweep over the packet, or a single-cycle adder over all bytes. A downstream link-layer encoder would consume the stream.

Top module: `audio_ifr_tx`

## Requirements
- R1: After reset `m_valid_o` and `busy_o` are low, and they stay low until a start pulse arrives.
- R2: Each start accepted while idle produces exactly 14 transfers. `m_last_o` is high on the 14th transfer only.
- R3: Transfers 0, 1 and 2 carry 0x84, 0x01 and 0x0A.
- R4: Transfer 4 (payload byte 1) is `coding_type_i` in bits 7:4, zero in bit 3, and `chan_count_i − 1` (low 3 bits) in bits 2:0.
- R5: Transfer 5 (payload byte 2) is zero in bits 7:5, `samp_freq_i` in bits 4:2 and `samp_size_i` in bits 1:0.
- R6: Transfer 6 (payload byte 3) is 0x00, and transfer 7 (payload byte 4) equals `chan_alloc_i`.
- R7: Transfer 8 (payload byte 5) has `dmix_inh_i` in bit 7, `lvl_shift_i` in bits 6:3 and zeros in bits 2:0.
- R8: Transfers 9 to 13 (payload bytes 6 to 10) are 0x00.
- R9: Transfer 3 is the checksum, so the 8-bit sum of all 14 transferred bytes is zero.
- R10: While `m_valid_o` is high and `m_ready_i` is low, the next cycle still shows `m_valid_o` high with `m_data_o` and `m_last_o` unchanged.
- R11: The configuration inputs are captured on the accepted start pulse. Later changes to them do not alter the packet in flight.
- R12: A start pulse while `busy_o` is high is ignored: the packet in flight is unchanged and no extra packet follows. `m_valid_o` is only high while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Capture configuration and begin a packet |
| coding_type_i | input | 4 | Audio coding type code |
| chan_count_i | input | 4 | Channel count, 1 to 8 |
| samp_freq_i | input | 3 | Sample frequency code |
| samp_size_i | input | 2 | Sample size code |
| chan_alloc_i | input | 8 | Speaker allocation value |
| dmix_inh_i | input | 1 | Downmix-inhibit flag |
| lvl_shift_i | input | 4 | Level-shift value |
| busy_o | output | 1 | Packet being summed or sent |
| m_valid_o | output | 1 | Output byte valid |
| m_data_o | output | 8 | Output byte |
| m_last_o | output | 1 | Final byte of the packet |
| m_ready_i | input | 1 | Downstream accepts the byte |

## Verification
The checker counts handshakes from reset to locate packet boundaries, so it assumes that every packet is drained to its last byte before the next one is counted. The bench never abandons a packet midway. The header and zero-sum properties assume that `chan_count_i` lies in 1..8, and the stimulus draws channel counts only from that range. `m_ready_i` is driven on the falling edge only, so stalls begin and end between clock edges. The stimulus includes single- and multi-cycle stalls, configuration changes after capture, and a start pulse during transmission.

// File: rtl/aif_pkg.sv
package aif_pkg;
   localparam int CT_W = 4;
   localparam int CC_W = 4;
   localparam int SF_W = 3;
   localparam int SS_W = 2;
   localparam int CA_W = 8;
   localparam int LS_W = 4;

   typedef struct packed {
      logic [CT_W-1:0] coding;
      logic [CC_W-1:0] ch_count;
      logic [SF_W-1:0] sfreq;
      logic [SS_W-1:0] ssize;
      logic [CA_W-1:0] alloc;
      logic            dmix;
      logic [LS_W-1:0] lshift;
   } aif_cfg_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SUM  = 2'd1,
      ST_SEND = 2'd2
   } aif_state_e;
endpackage

// File: rtl/aif_cfg_latch.sv
module aif_cfg_latch
   import aif_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     load_i,
   input  aif_cfg_t cfg_i,
   output aif_cfg_t cfg_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)       cfg_o <= '0;
      else if (load_i)  cfg_o <= cfg_i;
   end
endmodule

// File: rtl/aif_byte_map.sv
module aif_byte_map
   import aif_pkg::*;
#(
   parameter int         DATA_LEN = 10,
   parameter logic [7:0] HDR_TYPE = 8'h84,
   parameter logic [7:0] HDR_VER  = 8'h01,
   localparam int        NB       = 3 + DATA_LEN
)(
   input  aif_cfg_t   cfg_i,
   output logic [7:0] plain_o [NB]
);
   logic [CC_W-1:0] cc_m1;
   logic [7:0]      pay [DATA_LEN];

   assign cc_m1 = cfg_i.ch_count - CC_W'(1);

   always_comb begin
      for (int i = 0; i < DATA_LEN; i++) pay[i] = 8'h00;
      pay[0] = {cfg_i.coding, 1'b0, cc_m1[2:0]};
      pay[1] = {3'b000, cfg_i.sfreq, cfg_i.ssize};
      pay[3] = cfg_i.alloc;
      pay[4] = {cfg_i.dmix, cfg_i.lshift, 3'b000};
   end

   assign plain_o[0] = HDR_TYPE;
   assign plain_o[1] = HDR_VER;
   assign plain_o[2] = 8'(DATA_LEN);

   for (genvar g = 0; g < DATA_LEN; g++) begin : g_pay
      assign plain_o[3+g] = pay[g];
   end
endmodule

// File: rtl/aif_sum_unit.sv
module aif_sum_unit #(
   parameter int  NB      = 13,
   parameter bit  SWEEP   = 1'b1,
   localparam int P_W     = $clog2(NB)
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear_i,
   input  logic [7:0] plain_i [NB],
   output logic [7:0] csum_o,
   output logic       done_o
);
   logic [7:0] acc;

   assign csum_o = 8'h00 - acc;

   if (SWEEP) begin : g_sweep
      logic [P_W-1:0] pos;
      logic           run;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            acc    <= '0;
            pos    <= '0;
            run    <= 1'b0;
            done_o <= 1'b0;
         end else if (clear_i) begin
            acc    <= '0;
            pos    <= '0;
            run    <= 1'b1;
            done_o <= 1'b0;
         end else if (run) begin
            acc    <= acc + plain_i[pos];
            done_o <= (pos == P_W'(NB-1));
            if (pos == P_W'(NB-1)) begin
               run <= 1'b0;
               pos <= '0;
            end else begin
               pos <= pos + P_W'(1);
            end
         end else begin
            done_o <= 1'b0;
         end
      end
   end else begin : g_flat
      logic [7:0] tot;
      logic       pend;
      always_comb begin
         tot = '0;
         for (int i = 0; i < NB; i++) tot = tot + plain_i[i];
      end
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            acc    <= '0;
            pend   <= 1'b0;
            done_o <= 1'b0;
         end else begin
            pend   <= clear_i;
            done_o <= pend;
            if (pend) acc <= tot;
         end
      end
   end
endmodule

// File: rtl/aif_out_seq.sv
module aif_out_seq
   import aif_pkg::*;
#(
   parameter int  NB      = 13,
   localparam int PKT_LEN = NB + 1,
   localparam int Q_W     = $clog2(PKT_LEN)
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       sum_done_i,
   input  logic [7:0] plain_i [NB],
   input  logic [7:0] csum_i,
   output logic       load_o,
   output logic       busy_o,
   output logic       valid_o,
   output logic [7:0] data_o,
   output logic       last_o,
   input  logic       ready_i
);
   aif_state_e     st;
   logic [Q_W-1:0] q;

   assign load_o  = (st == ST_IDLE) && start_i;
   assign busy_o  = (st != ST_IDLE);
   assign valid_o = (st == ST_SEND);
   assign last_o  = valid_o && (q == Q_W'(PKT_LEN-1));

   always_comb begin
      if (q < Q_W'(3))       data_o = plain_i[q];
      else if (q == Q_W'(3)) data_o = csum_i;
      else                   data_o = plain_i[q - Q_W'(1)];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= ST_IDLE;
         q  <= '0;
      end else begin
         case (st)
            ST_IDLE: if (start_i) st <= ST_SUM;
            ST_SUM: if (sum_done_i) begin
               st <= ST_SEND;
               q  <= '0;
            end
            ST_SEND: if (ready_i) begin
               if (q == Q_W'(PKT_LEN-1)) begin
                  st <= ST_IDLE;
                  q  <= '0;
               end else begin
                  q <= q + Q_W'(1);
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/audio_ifr_tx.sv
module audio_ifr_tx
   import aif_pkg::*;
#(
   parameter int         DATA_LEN = 10,
   parameter logic [7:0] HDR_TYPE = 8'h84,
   parameter logic [7:0] HDR_VER  = 8'h01,
   parameter bit         SWEEP    = 1'b1,
   localparam int        NB       = 3 + DATA_LEN
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CT_W-1:0]  coding_type_i,
   input  logic [CC_W-1:0]  chan_count_i,
   input  logic [SF_W-1:0]  samp_freq_i,
   input  logic [SS_W-1:0]  samp_size_i,
   input  logic [CA_W-1:0]  chan_alloc_i,
   input  logic             dmix_inh_i,
   input  logic [LS_W-1:0]  lvl_shift_i,
   output logic             busy_o,
   output logic             m_valid_o,
   output logic [7:0]       m_data_o,
   output logic             m_last_o,
   input  logic             m_ready_i
);
   if (DATA_LEN < 5 || DATA_LEN > 27) begin : g_bad_len
      $error("audio_ifr_tx: DATA_LEN out of range");
   end
   if (CT_W + 4 > 8 || SF_W + SS_W > 8 || LS_W + 4 > 8) begin : g_bad_fld
      $error("audio_ifr_tx: field widths do not fit a byte");
   end

   aif_cfg_t   cfg_in, cfg_q;
   logic       load, sum_done;
   logic [7:0] csum;
   logic [7:0] plain [NB];

   assign cfg_in = '{coding: coding_type_i, ch_count: chan_count_i,
                     sfreq: samp_freq_i, ssize: samp_size_i,
                     alloc: chan_alloc_i, dmix: dmix_inh_i,
                     lshift: lvl_shift_i};

   aif_cfg_latch u_latch (
      .clk(clk), .rst_n(rst_n), .load_i(load), .cfg_i(cfg_in), .cfg_o(cfg_q)
   );

   aif_byte_map #(.DATA_LEN(DATA_LEN), .HDR_TYPE(HDR_TYPE), .HDR_VER(HDR_VER))
   u_map (.cfg_i(cfg_q), .plain_o(plain));

   aif_sum_unit #(.NB(NB), .SWEEP(SWEEP)) u_sum (
      .clk(clk), .rst_n(rst_n), .clear_i(load), .plain_i(plain),
      .csum_o(csum), .done_o(sum_done)
   );

   aif_out_seq #(.NB(NB)) u_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .sum_done_i(sum_done),
      .plain_i(plain), .csum_i(csum), .load_o(load), .busy_o(busy_o),
      .valid_o(m_valid_o), .data_o(m_data_o), .last_o(m_last_o),
      .ready_i(m_ready_i)
   );
endmodule

// File: rtl/aif_ifr_chk.sv
module aif_ifr_chk #(
   parameter int         DATA_LEN = 10,
   parameter logic [7:0] HDR_TYPE = 8'h84,
   localparam int        PKT_LEN  = 4 + DATA_LEN,
   localparam int        C_W      = $clog2(PKT_LEN)
)(
   input logic       clk,
   input logic       rst_n,
   input logic       busy_o,
   input logic       m_valid_o,
   input logic [7:0] m_data_o,
   input logic       m_last_o,
   input logic       m_ready_i
);
   logic [C_W-1:0] cnt;
   logic [7:0]     run_sum;
   logic [7:0]     fin_sum;

   assign fin_sum = run_sum + m_data_o;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= '0;
         run_sum <= '0;
      end else if (m_valid_o && m_ready_i) begin
         if (m_last_o) begin
            cnt     <= '0;
            run_sum <= '0;
         end else begin
            cnt     <= cnt + C_W'(1);
            run_sum <= fin_sum;
         end
      end
   end

   assert_last_pos_R2: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid_o |-> (m_last_o == (cnt == C_W'(PKT_LEN-1))));

   assert_hdr_type_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid_o && cnt == '0) |-> (m_data_o == HDR_TYPE));

   assert_zero_sum_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid_o && m_ready_i && m_last_o) |-> (fin_sum == 8'h00));

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid_o && !m_ready_i) |=>
         (m_valid_o && $stable(m_data_o) && $stable(m_last_o)));

   assert_valid_in_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid_o |-> busy_o);
endmodule

bind audio_ifr_tx aif_ifr_chk #(.DATA_LEN(DATA_LEN), .HDR_TYPE(HDR_TYPE)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .m_valid_o(m_valid_o),
   .m_data_o(m_data_o), .m_last_o(m_last_o), .m_ready_i(m_ready_i)
);

// File: tb/audio_ifr_tx_tb_top.sv
module audio_ifr_tx_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NPKT = 14;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [3:0] coding_type_i = '0;
   logic [3:0] chan_count_i = 4'd1;
   logic [2:0] samp_freq_i = '0;
   logic [1:0] samp_size_i = '0;
   logic [7:0] chan_alloc_i = '0;
   logic       dmix_inh_i = 1'b0;
   logic [3:0] lvl_shift_i = '0;
   logic       busy_o, m_valid_o, m_last_o;
   logic [7:0] m_data_o;
   logic       m_ready_i = 1'b0;

   int n_chk = 0;
   int n_fail = 0;
   logic [7:0] exp_b [NPKT];
   logic [7:0] got_b [NPKT];
   logic       got_l [NPKT];

   always #(CLK_PERIOD/2) clk = ~clk;

   audio_ifr_tx dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .coding_type_i(coding_type_i), .chan_count_i(chan_count_i),
      .samp_freq_i(samp_freq_i), .samp_size_i(samp_size_i),
      .chan_alloc_i(chan_alloc_i), .dmix_inh_i(dmix_inh_i),
      .lvl_shift_i(lvl_shift_i), .busy_o(busy_o), .m_valid_o(m_valid_o),
      .m_data_o(m_data_o), .m_last_o(m_last_o), .m_ready_i(m_ready_i)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic string req_of(input int i);
      case (i)
         0, 1, 2: return "R3 header";
         3:       return "R9 checksum";
         4:       return "R4 payload1";
         5:       return "R5 payload2";
         6, 7:    return "R6 payload3/4";
         8:       return "R7 payload5";
         default: return "R8 zero payload";
      endcase
   endfunction

   task automatic build_exp(input logic [3:0] ct, input logic [3:0] cc,
                            input logic [2:0] sf, input logic [1:0] ss,
                            input logic [7:0] ca, input logic dm,
                            input logic [3:0] ls);
      logic [3:0] ccm;
      logic [7:0] s;
      ccm = cc - 4'd1;
      for (int i = 0; i < NPKT; i++) exp_b[i] = 8'h00;
      exp_b[0] = 8'h84; exp_b[1] = 8'h01; exp_b[2] = 8'h0A;
      exp_b[4] = {ct, 1'b0, ccm[2:0]};
      exp_b[5] = {3'b000, sf, ss};
      exp_b[7] = ca;
      exp_b[8] = {dm, ls, 3'b000};
      s = 8'h00;
      for (int i = 0; i < NPKT; i++) if (i != 3) s = s + exp_b[i];
      exp_b[3] = 8'h00 - s;
   endtask

   task automatic drive_cfg(input logic [3:0] ct, input logic [3:0] cc,
                            input logic [2:0] sf, input logic [1:0] ss,
                            input logic [7:0] ca, input logic dm,
                            input logic [3:0] ls);
      coding_type_i = ct; chan_count_i = cc; samp_freq_i = sf;
      samp_size_i = ss; chan_alloc_i = ca; dmix_inh_i = dm; lvl_shift_i = ls;
   endtask

   task automatic pulse_start();
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
   endtask

   // mode 0: always ready, 1: alternate, 2: long stalls.
   // mid: 1 scrambles config after capture, 2 also pulses start while busy.
   task automatic collect(input int mode, input int mid);
      int  k = 0, cyc = 0, wait_c = 0;
      bit  held = 0;
      logic [7:0] hd;
      logic hl;
      bit r;
      while (k < NPKT && wait_c < 400) begin
         @(negedge clk);
         wait_c++;
         start_i = 1'b0;
         if (held) begin
            check(m_valid_o && m_data_o == hd && m_last_o == hl, "R10 hold",
                  m_data_o, hd);
            held = 0;
         end
         if (mid >= 1 && wait_c == 2) drive_cfg(4'hF, 4'd8, 3'd7, 2'd3, 8'hFF, 1'b1, 4'hF);
         if (mid == 2 && k == 5) start_i = 1'b1;
         if (m_valid_o) begin
            case (mode)
               0: r = 1'b1;
               1: r = cyc[0];
               default: r = (cyc % 4) == 3;
            endcase
            cyc++;
            m_ready_i = r;
            if (r) begin
               got_b[k] = m_data_o; got_l[k] = m_last_o; k++;
            end else begin
               held = 1; hd = m_data_o; hl = m_last_o;
            end
         end else begin
            m_ready_i = 1'b0;
         end
      end
      check(k == NPKT, "R2 byte count", k, NPKT);
      @(negedge clk);
      m_ready_i = 1'b0;
      start_i = 1'b0;
   endtask

   task automatic compare(input string tag);
      for (int i = 0; i < NPKT; i++) begin
         check(got_b[i] == exp_b[i], {req_of(i), " ", tag}, got_b[i], exp_b[i]);
         check(got_l[i] == (i == NPKT-1), "R2 last flag", got_l[i], i == NPKT-1);
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check(!m_valid_o && !busy_o, "R1 reset idle", {m_valid_o, busy_o}, 0);
   endtask

   task automatic t_basic();
      drive_cfg(4'h1, 4'd2, 3'd3, 3'h1, 8'h13, 1'b0, 4'h0);
      build_exp(4'h1, 4'd2, 3'd3, 2'h1, 8'h13, 1'b0, 4'h0);
      pulse_start();
      collect(0, 0);
      compare("basic");
   endtask

   task automatic t_stall();
      drive_cfg(4'hA, 4'd8, 3'd5, 2'd2, 8'h31, 1'b1, 4'h9);
      build_exp(4'hA, 4'd8, 3'd5, 2'd2, 8'h31, 1'b1, 4'h9);
      pulse_start();
      collect(1, 0);
      compare("alternate R10");
      drive_cfg(4'h0, 4'd1, 3'd0, 2'd0, 8'h00, 1'b0, 4'h0);
      build_exp(4'h0, 4'd1, 3'd0, 2'd0, 8'h00, 1'b0, 4'h0);
      pulse_start();
      collect(2, 0);
      compare("long stall R10");
   endtask

   task automatic t_cfg_change();
      drive_cfg(4'h5, 4'd6, 3'd2, 2'd1, 8'h0B, 1'b1, 4'h3);
      build_exp(4'h5, 4'd6, 3'd2, 2'd1, 8'h0B, 1'b1, 4'h3);
      pulse_start();
      collect(0, 1);
      compare("R11 config changed");
   endtask

   task automatic t_start_busy();
      bit extra = 0;
      drive_cfg(4'h7, 4'd3, 3'd6, 2'd3, 8'h2A, 1'b0, 4'hC);
      build_exp(4'h7, 4'd3, 3'd6, 2'd3, 8'h2A, 1'b0, 4'hC);
      pulse_start();
      collect(1, 2);
      compare("R12 start while busy");
      m_ready_i = 1'b1;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (m_valid_o || busy_o) extra = 1;
      end
      m_ready_i = 1'b0;
      check(!extra, "R12 no extra packet", extra, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0x1 expected=0x0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_basic();
      t_stall();
      t_cfg_change();
      t_start_busy();
      t_basic();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule